// File: doc/BRIEF.md
# Bus Wait Timeout Retract Controller

This block watches external bus accesses that a slow peripheral is holding off. It monitors three wait sources: two active-low card-slot wait lines and one active-high expansion-bus hold line. It counts how many consecutive clocks the combined wait condition has been present. When the wait lasts longer than a programmable limit and retracts are enabled, it issues a one-cycle retract pulse. The bus can then be freed, so a DMA engine that shares the bus is not stalled for the whole of the slow access.

Software controls the block through a small register with two fields, an enable and a delay select (short or long timeout). The same register returns a sticky flag that records that a retract happened. Software clears that flag by writing 1 to it. The DMA engine, bus arbitration and re-issue of the aborted access all sit outside this block.

Top module: `bus_wait_retract`

## Requirements
- R1: After a synchronous reset, reg_rdata reads 0 (enable clear, short delay selected, flag clear) and retract_pulse is low.
- R2: The wait condition is present in a cycle when slot_a_wait_n is 0, or slot_b_wait_n is 0, or exp_hold is 1. A wait handed over from one source to another without a gap counts as one continuous wait.
- R3: With bit 0 of the register at 0 and bit 1 at 1, a wait sampled on 9 consecutive rising edges gives retract_pulse high in the cycle after the 9th edge. A wait of only 8 edges gives no pulse.
- R4: With bit 0 at 1 and bit 1 at 1, the pulse follows the 13th consecutive wait edge. A wait of 12 edges gives no pulse.
- R5: While bit 1 (enable) is 0, retract_pulse stays low however long the wait lasts. If enable is set while a wait is already past its limit, the pulse comes on the first wait edge after the write.
- R6: Any cycle without the wait condition restarts the count, so only continuous waits can cause a retract.
- R7: retract_pulse is high for exactly one cycle per wait episode. It fires again only after the wait is released and re-asserted for long enough.
- R8: A write with reg_wr high loads bit 0 (delay select) and bit 1 (enable) from reg_wdata. reg_rdata returns those in bits 1:0, the sticky flag in bit 2, and 0 in every higher bit.
- R9: The sticky flag (reg_rdata bit 2, also retract_flag) is set together with each retract pulse. It is cleared by a write with reg_wdata bit 2 at 1, and a write with bit 2 at 0 leaves it unchanged. If a clear and a new retract happen on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read value |
| slot_a_wait_n | input | 1 | Card slot A wait, active low |
| slot_b_wait_n | input | 1 | Card slot B wait, active low |
| exp_hold | input | 1 | Expansion bus not-ready hold, active high |
| retract_pulse | output | 1 | One-cycle bus retract request |
| retract_flag | output | 1 | Sticky retract-occurred flag |

## Verification
The cases that are hardest to reach from the ports involve a register write that must land on the exact edge where the wait count reaches its limit. One such case is a flag clear on the same edge as a new retract. Others are enabling retracts, or switching the delay select, while a wait is already under way. The stimulus reaches these by counting wait edges from the moment the wait is asserted, then placing the write in the cycle just before the limit edge. A long wait with retracts disabled is then enabled part-way through.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam int SEL_BIT  = 0;
  localparam int EN_BIT   = 1;
  localparam int FLAG_BIT = 2;

  typedef struct packed {
    logic en;
    logic sel_long;
  } bwr_ctrl_t;
endpackage

// File: rtl/bwr_wait_merge.sv
module bwr_wait_merge #(
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC-1:0] ACTIVE_LOW = 3'b011
) (
  input  logic [NUM_SRC-1:0] src,
  output logic               wait_any
);
  logic [NUM_SRC-1:0] active;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_norm
    if (ACTIVE_LOW[i]) begin : g_low
      assign active[i] = ~src[i];
    end else begin : g_high
      assign active[i] = src[i];
    end
  end

  assign wait_any = |active;
endmodule

// File: rtl/bwr_timeout.sv
module bwr_timeout #(
  parameter int SHORT_DELAY = 8,
  parameter int LONG_DELAY  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_any,
  input  logic enable,
  input  logic sel_long,
  output logic fire,
  output logic pulse
);
  localparam int MAX_D = (LONG_DELAY > SHORT_DELAY) ? LONG_DELAY : SHORT_DELAY;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_DELAY);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_DELAY);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_D);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             done;

  assign limit = sel_long ? LONG_C : SHORT_C;
  assign fire  = wait_any && enable && !done && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (!wait_any) begin
        cnt  <= '0;
        done <= 1'b0;
      end else begin
        if (cnt < MAX_C) cnt <= cnt + 1'b1;
        if (fire) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwr_ctrl_reg.sv
module bwr_ctrl_reg
  import bwr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        wbits,
  input  logic              fire,
  output bwr_ctrl_t         ctrl,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      if (wr) begin
        ctrl.sel_long <= wbits[SEL_BIT];
        ctrl.en       <= wbits[EN_BIT];
      end
      if (fire) flag <= 1'b1;
      else if (wr && wbits[FLAG_BIT]) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[SEL_BIT]  = ctrl.sel_long;
    rdata[EN_BIT]   = ctrl.en;
    rdata[FLAG_BIT] = flag;
  end
endmodule

// File: rtl/bus_wait_retract.sv
module bus_wait_retract
  import bwr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SHORT_DELAY = 8,
  parameter int LONG_DELAY  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              slot_a_wait_n,
  input  logic              slot_b_wait_n,
  input  logic              exp_hold,
  output logic              retract_pulse,
  output logic              retract_flag
);
  bwr_ctrl_t ctrl;
  logic      wait_any;
  logic      fire;
  logic      unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:3];

  bwr_wait_merge #(.NUM_SRC(3), .ACTIVE_LOW(3'b011)) u_merge (
    .src      ({exp_hold, slot_b_wait_n, slot_a_wait_n}),
    .wait_any (wait_any)
  );

  bwr_timeout #(.SHORT_DELAY(SHORT_DELAY), .LONG_DELAY(LONG_DELAY)) u_timeout (
    .clk      (clk),
    .rst      (rst),
    .wait_any (wait_any),
    .enable   (ctrl.en),
    .sel_long (ctrl.sel_long),
    .fire     (fire),
    .pulse    (retract_pulse)
  );

  bwr_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wbits (reg_wdata[2:0]),
    .fire  (fire),
    .ctrl  (ctrl),
    .flag  (retract_flag),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
  parameter int DATA_W      = 32,
  parameter int SHORT_DELAY = 8,
  parameter int LONG_DELAY  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              slot_a_wait_n,
  input logic              slot_b_wait_n,
  input logic              exp_hold,
  input logic              retract_pulse,
  input logic              retract_flag
);
  logic       wait_any;
  logic [7:0] run;

  assign wait_any = !slot_a_wait_n || !slot_b_wait_n || exp_hold;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (!wait_any) run <= '0;
    else if (run != 8'hFF) run <= run + 8'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !retract_pulse));

  assert_needs_wait_R2: assert property (@(posedge clk) disable iff (rst)
    retract_pulse |-> $past(wait_any));

  assert_min_wait_R3_R4: assert property (@(posedge clk) disable iff (rst)
    retract_pulse |-> (int'($past(run)) >= ($past(reg_rdata[0]) ? LONG_DELAY : SHORT_DELAY)));

  assert_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    retract_pulse |-> $past(reg_rdata[1]));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    retract_pulse |=> !retract_pulse);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:3] == '0);

  assert_flag_on_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    retract_pulse |-> (retract_flag && reg_rdata[2]));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (retract_flag && !(reg_wr && reg_wdata[2])) |=> retract_flag);
endmodule

bind bus_wait_retract bwr_checker #(
  .DATA_W(DATA_W), .SHORT_DELAY(SHORT_DELAY), .LONG_DELAY(LONG_DELAY)
) u_bwr_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .slot_a_wait_n(slot_a_wait_n),
  .slot_b_wait_n(slot_b_wait_n), .exp_hold(exp_hold),
  .retract_pulse(retract_pulse), .retract_flag(retract_flag)
);

// File: tb/bus_wait_retract_tb.sv
`timescale 1ns/1ps
module bus_wait_retract_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          slot_a_wait_n = 1'b1;
  logic          slot_b_wait_n = 1'b1;
  logic          exp_hold = 1'b0;
  logic          retract_pulse;
  logic          retract_flag;

  always #4 clk = ~clk;

  bus_wait_retract #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .slot_a_wait_n(slot_a_wait_n),
    .slot_b_wait_n(slot_b_wait_n), .exp_hold(exp_hold),
    .retract_pulse(retract_pulse), .retract_flag(retract_flag)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  int    pulses = 0;
  string tag = "R1";
  bit    finished = 0;

  // behavioural reference model
  bit m_sel, m_en, m_flag, m_pulse, m_done;
  int m_run;

  always @(posedge clk) begin
    bit w, fire;
    int lim;
    if (rst) begin
      m_sel = 0; m_en = 0; m_flag = 0; m_pulse = 0; m_done = 0; m_run = 0;
    end else begin
      w    = !slot_a_wait_n || !slot_b_wait_n || exp_hold;
      lim  = m_sel ? 12 : 8;
      fire = w && m_en && !m_done && (m_run >= lim);
      m_pulse = fire;
      if (w) begin
        m_run++;
        if (fire) m_done = 1;
      end else begin
        m_run = 0;
        m_done = 0;
      end
      if (fire) m_flag = 1;
      else if (reg_wr && reg_wdata[2]) m_flag = 0;
      if (reg_wr) begin
        m_sel = reg_wdata[0];
        m_en  = reg_wdata[1];
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [DW-1:0] e;
      e = {29'd0, m_flag, m_en, m_sel};
      check(retract_pulse == m_pulse, {tag, " pulse"}, retract_pulse, m_pulse);
      check(reg_rdata == e, {tag, " rdata"}, reg_rdata, e);
      check(retract_flag == m_flag, {tag, " flag"}, retract_flag, m_flag);
      if (retract_pulse) pulses++;
    end
  end

  task automatic idle(input int n);
    slot_a_wait_n = 1; slot_b_wait_n = 1; exp_hold = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input bit a_n, input bit b_n, input bit h, input int n);
    slot_a_wait_n = a_n; slot_b_wait_n = b_n; exp_hold = h;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic expect_pulses(input int n, input string req);
    check(pulses == n, {req, " pulse count"}, pulses, n);
    pulses = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    check(reg_rdata == '0, "R1 reset rdata", reg_rdata, 0);
    check(retract_pulse == 0, "R1 reset pulse", retract_pulse, 0);
    pulses = 0;

    tag = "R5";
    hold(0, 1, 0, 20); idle(2);
    expect_pulses(0, "R5 disabled");

    tag = "R3";
    wr(32'h2);
    hold(1, 0, 1, 9); idle(2);
    expect_pulses(1, "R3 nine edges");
    hold(1, 0, 1, 8); idle(2);
    expect_pulses(0, "R3 eight edges");

    tag = "R7";
    hold(1, 1, 1, 30); idle(1);
    hold(1, 1, 1, 10); idle(2);
    expect_pulses(2, "R7 one per episode");

    tag = "R6";
    hold(0, 1, 0, 5); idle(1); hold(0, 1, 0, 5); idle(2);
    expect_pulses(0, "R6 gap restarts");

    tag = "R2";
    hold(0, 1, 0, 3); hold(0, 0, 0, 3); hold(1, 0, 1, 3); hold(1, 1, 1, 1); idle(2);
    expect_pulses(1, "R2 handover");

    tag = "R4";
    wr(32'h3);
    hold(1, 1, 1, 12); idle(2);
    expect_pulses(0, "R4 twelve edges");
    hold(1, 0, 0, 13); idle(2);
    expect_pulses(1, "R4 thirteen edges");

    tag = "R9";
    wr(32'h3);
    check(retract_flag == 1, "R9 flag kept on bit2=0", retract_flag, 1);
    wr(32'h7);
    check(reg_rdata[2] == 0, "R9 flag cleared", reg_rdata[2], 0);
    hold(0, 1, 0, 12);
    reg_wr = 1; reg_wdata = 32'h7;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
    check(retract_flag == 1, "R9 set wins over clear", retract_flag, 1);
    idle(2);
    expect_pulses(1, "R9 collision pulse");

    tag = "R5";
    wr(32'h4);
    hold(1, 1, 1, 15);
    wr(32'h2);
    hold(1, 1, 1, 3); idle(2);
    expect_pulses(1, "R5 late enable");

    tag = "R3";
    wr(32'h3);
    hold(0, 1, 0, 10);
    wr(32'h2);
    hold(0, 1, 0, 2); idle(2);
    expect_pulses(1, "R3 select change mid-wait");

    tag = "R8";
    wr(32'hFFFF_FFF9);
    check(reg_rdata == 32'h1 || reg_rdata == 32'h5, "R8 upper bits zero", reg_rdata, 32'h1);
    idle(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule